// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a behavioural model of a synchronous burst memory with a pipelined read path. The data word is 32 bits wide and split into four byte lanes. Every rising clock edge is decoded into one of four cycle kinds: deselect, burst start, burst continue, or burst suspend. A burst start, continue or suspend cycle acts as a read or as a write. Reads pass through an output register, so data for an address taken on one edge appears after the next edge. Writes go straight into the array at the edge that resolves them, with a byte mask.

There are two ways to start a burst. The host strobe always starts with a read cycle and ignores the write controls. A write that follows on the next edge (a suspend) lands on the start address. The controller strobe starts a cycle whose direction is set at once by the write controls. After a start, the two low address bits step through a four-beat sequence, either linear or interleaved, under the advance input.

Three chip enables qualify the strobes. The output driver is gated asynchronously by an output enable. A sleep input holds the array contents, forces the outputs to high impedance, and is followed by a recovery window during which strobes are ignored. The tri-state bus is modelled as separate data-in, data-out and drive-enable ports.

Top module: `pburst_sram`

## Requirements
- R1: A strobe counts as a selecting start only when en0_n_i=0, en1_i=1 and en2_n_i=0. A strobe seen with any enable inactive deselects the device. The host strobe is ignored entirely while en0_n_i=1, and the cycle is then treated as if no strobe were present.
- R2: A read taken on edge N loads the output register on edge N+1. After edge N+1, dout_o carries the addressed word and dout_en_o=1 (when oe_n_i=0 and sleep_i=0). Out of reset dout_en_o=0.
- R3: After a deselect edge N, dout_en_o is 0 from edge N+1 onward. A read taken on edge N-1 is still presented after edge N.
- R4: A controller-strobe start (strb_ctl_n_i=0 with the host strobe not taken) with a write control active writes din_i to addr_i at that same edge.
- R5: A host-strobe start is always a read of addr_i, whatever wr_all_n_i, wr_byte_n_i and lane_n_i show. The write controls and data sampled on the following edge decide whether a write happens there.
- R6: wr_all_n_i=0 writes all four lanes, overriding wr_byte_n_i and lane_n_i.
- R7: With wr_all_n_i=1 and wr_byte_n_i=0, lane k (bits 8k+7:8k of din_i) is written only if lane_n_i[k]=0. If wr_byte_n_i=1, or no lane bit is low, the cycle is a read.
- R8: A continue cycle (no strobe taken, adv_n_i=0, burst active) advances a two-bit beat count that wraps after four beats. The low address bits are start+count mod 4 when mode_il_i=0 and start XOR count when mode_il_i=1. The upper address bits stay fixed.
- R9: A suspend cycle (no strobe taken, adv_n_i=1, burst active) keeps the current beat address. In continue and suspend cycles the direction comes from the write controls of that cycle.
- R10: oe_n_i=1 forces dout_en_o=0 at once, without waiting for a clock edge.
- R11: sleep_i=1 forces dout_en_o=0 at once and leaves the array unchanged. During the RECOV_CYC edges after sleep_i falls, strobes are ignored and nothing is written.
- R12: After a start that follows a deselected period, dout_en_o stays 0 until the edge after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sleep_i | input | 1 | Low-power hold, active high, asynchronous on the outputs |
| mode_il_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| en0_n_i | input | 1 | First chip enable, active low, also qualifies the host strobe |
| en1_i | input | 1 | Second chip enable, active high |
| en2_n_i | input | 1 | Third chip enable, active low |
| strb_host_n_i | input | 1 | Host start strobe, active low, takes priority |
| strb_ctl_n_i | input | 1 | Controller start strobe, active low |
| adv_n_i | input | 1 | Advance, active low: step the burst |
| wr_all_n_i | input | 1 | Whole-word write, active low |
| wr_byte_n_i | input | 1 | Byte write function enable, active low |
| lane_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output drive enable, active low, asynchronous |
| addr_i | input | ADDR_W | Word address |
| din_i | input | LANES*LANE_W | Write data |
| dout_o | output | LANES*LANE_W | Output register contents |
| dout_en_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The bench targets the host-strobe start that carries an active whole-word write. A model that honoured it would overwrite the start address, and the later read-back would show the corrupted word instead of the original. It also checks the burst wrap and the two beat orders from an odd start address. An adder used in interleaved mode would return the beats as 9,10,11,8 instead of 9,8,11,10. The bench checks the two deselect timings: a pending read must still appear after the deselect edge, and the bus must float one edge later. Finally it probes the last edge of the sleep recovery window with a write that must not reach the array; an off-by-one counter would let that write through.

// File: rtl/pburst_pkg.sv
`timescale 1ns/1ps
package pburst_pkg;

    // Kind of access decoded at a rising edge
    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_DESEL   = 3'd1,
        CYC_BEGIN_H = 3'd2,
        CYC_BEGIN_C = 3'd3,
        CYC_CONT    = 3'd4,
        CYC_SUSP    = 3'd5
    } cyc_e;

endpackage

// File: rtl/pburst_decode.sv
`timescale 1ns/1ps
module pburst_decode
    import pburst_pkg::*;
(
    input  logic blocked_i,
    input  logic active_i,
    input  logic host_n_i,
    input  logic ctl_n_i,
    input  logic adv_n_i,
    input  logic en0_n_i,
    input  logic en1_i,
    input  logic en2_n_i,
    output cyc_e cyc_o
);

    logic host_take;
    logic ctl_take;
    logic selected;

    always_comb begin
        // host strobe only counts while the first enable is active
        host_take = !host_n_i && !en0_n_i;
        ctl_take  = !ctl_n_i && !host_take;
        selected  = !en0_n_i && en1_i && !en2_n_i;
        cyc_o     = CYC_IDLE;
        if (blocked_i) begin
            cyc_o = CYC_IDLE;
        end else if (host_take || ctl_take) begin
            if (!selected)      cyc_o = CYC_DESEL;
            else if (host_take) cyc_o = CYC_BEGIN_H;
            else                cyc_o = CYC_BEGIN_C;
        end else if (active_i) begin
            cyc_o = adv_n_i ? CYC_SUSP : CYC_CONT;
        end
    end

endmodule

// File: rtl/pburst_seq.sv
`timescale 1ns/1ps
module pburst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_i,
    input  logic [BURST_W-1:0] step_i,
    input  logic               interleave_i,
    output logic [BURST_W-1:0] idx_o
);

    logic [BURST_W-1:0] lin_idx;
    logic [BURST_W-1:0] xor_idx;

    always_comb begin
        lin_idx = base_i + step_i;
        xor_idx = base_i ^ step_i;
        idx_o   = interleave_i ? xor_idx : lin_idx;
    end

endmodule

// File: rtl/pburst_array.sv
`timescale 1ns/1ps
module pburst_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_i,
    input  logic [ADDR_W-1:0]       waddr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0]       raddr_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                lane_mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[raddr_i];
    end

endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram
    import pburst_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int BURST_W  = 2,
    parameter int RECOV_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_i,
    input  logic                    mode_il_i,
    input  logic                    en0_n_i,
    input  logic                    en1_i,
    input  logic                    en2_n_i,
    input  logic                    strb_host_n_i,
    input  logic                    strb_ctl_n_i,
    input  logic                    adv_n_i,
    input  logic                    wr_all_n_i,
    input  logic                    wr_byte_n_i,
    input  logic [LANES-1:0]        lane_n_i,
    input  logic                    oe_n_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] din_i,
    output logic [LANES*LANE_W-1:0] dout_o,
    output logic                    dout_en_o
);

    localparam int DW = LANES * LANE_W;
    localparam int RW = $clog2(RECOV_CYC + 1);

    typedef struct packed {
        logic               active;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        logic               rd_pend;
        logic [ADDR_W-1:0]  rd_addr;
        logic [DW-1:0]      dout;
        logic               dvld;
        logic [RW-1:0]      rec;
    } state_t;

    state_t state_d;
    state_t state_q;

    cyc_e               cyc_w;
    logic               accept_w;
    logic               begin_w;
    logic               burst_w;
    logic [BURST_W-1:0] step_w;
    logic [BURST_W-1:0] idx_w;
    logic [ADDR_W-1:0]  cyc_addr_w;
    logic [LANES-1:0]   wmask_w;
    logic [LANES-1:0]   we_w;
    logic               wr_en_w;
    logic               rd_en_w;
    logic [DW-1:0]      rdata_w;

    assign accept_w = !sleep_i && (state_q.rec == '0);

    pburst_decode u_decode (
        .blocked_i (!accept_w),
        .active_i  (state_q.active),
        .host_n_i  (strb_host_n_i),
        .ctl_n_i   (strb_ctl_n_i),
        .adv_n_i   (adv_n_i),
        .en0_n_i   (en0_n_i),
        .en1_i     (en1_i),
        .en2_n_i   (en2_n_i),
        .cyc_o     (cyc_w)
    );

    assign step_w = (cyc_w == CYC_CONT) ? state_q.cnt + 1'b1 : state_q.cnt;

    pburst_seq #(.BURST_W(BURST_W)) u_seq (
        .base_i       (state_q.base[BURST_W-1:0]),
        .step_i       (step_w),
        .interleave_i (mode_il_i),
        .idx_o        (idx_w)
    );

    pburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we_i    (we_w),
        .waddr_i (cyc_addr_w),
        .wdata_i (din_i),
        .raddr_i (state_q.rd_addr),
        .rdata_o (rdata_w)
    );

    // access decode: address, direction, byte mask
    always_comb begin
        begin_w = (cyc_w == CYC_BEGIN_H) || (cyc_w == CYC_BEGIN_C);
        burst_w = (cyc_w == CYC_BEGIN_C) || (cyc_w == CYC_CONT) || (cyc_w == CYC_SUSP);
        if (begin_w) cyc_addr_w = addr_i;
        else         cyc_addr_w = {state_q.base[ADDR_W-1:BURST_W], idx_w};
        if (!wr_all_n_i)       wmask_w = '1;
        else if (!wr_byte_n_i) wmask_w = ~lane_n_i;
        else                   wmask_w = '0;
        wr_en_w = burst_w && (wmask_w != '0);
        rd_en_w = (cyc_w == CYC_BEGIN_H) || (burst_w && (wmask_w == '0));
        we_w    = wr_en_w ? wmask_w : '0;
    end

    // next-state
    always_comb begin
        state_d = state_q;

        // read pipeline: address stage then output register
        state_d.rd_pend = rd_en_w;
        if (rd_en_w) state_d.rd_addr = cyc_addr_w;
        state_d.dvld = state_q.rd_pend && accept_w;
        if (state_q.rd_pend) state_d.dout = rdata_w;

        // sleep recovery window
        if (sleep_i)                  state_d.rec = RW'(RECOV_CYC);
        else if (state_q.rec != '0)   state_d.rec = state_q.rec - 1'b1;

        // burst tracking
        case (cyc_w)
            CYC_BEGIN_H, CYC_BEGIN_C: begin
                state_d.active = 1'b1;
                state_d.base   = addr_i;
                state_d.cnt    = '0;
            end
            CYC_CONT:  state_d.cnt    = state_q.cnt + 1'b1;
            CYC_DESEL: state_d.active = 1'b0;
            CYC_SUSP:  state_d.cnt    = state_q.cnt;
            default: begin
                if (!accept_w) state_d.active = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dout_o    = state_q.dout;
    assign dout_en_o = state_q.dvld && !oe_n_i && !sleep_i;

endmodule

// File: rtl/pburst_sram_chk.sv
`timescale 1ns/1ps
module pburst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_i,
    input logic oe_n_i,
    input logic en0_n_i,
    input logic en1_i,
    input logic en2_n_i,
    input logic strb_host_n_i,
    input logic strb_ctl_n_i,
    input logic ready_i,
    input logic dout_en_o
);

    logic sel_w;
    logic desel_w;
    logic host_rd_w;

    assign sel_w     = !en0_n_i && en1_i && !en2_n_i;
    assign desel_w   = ready_i && ((!strb_host_n_i && !en0_n_i) || !strb_ctl_n_i) && !sel_w;
    assign host_rd_w = ready_i && !strb_host_n_i && sel_w;

    AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        desel_w |-> ##2 !dout_en_o); // R3

    AST_HOST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_w |-> ##2 (dout_en_o || oe_n_i || sleep_i || $past(sleep_i))); // R5

    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dout_en_o); // R10

    AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !dout_en_o); // R11

endmodule

bind pburst_sram pburst_sram_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .oe_n_i        (oe_n_i),
    .en0_n_i       (en0_n_i),
    .en1_i         (en1_i),
    .en2_n_i       (en2_n_i),
    .strb_host_n_i (strb_host_n_i),
    .strb_ctl_n_i  (strb_ctl_n_i),
    .ready_i       (accept_w),
    .dout_en_o     (dout_en_o)
);

// File: tb/pburst_sram_tb_top.sv
`timescale 1ns/1ps
module pburst_sram_tb_top;

    localparam int RECOV = 4;
    localparam logic H = 1'b1;
    localparam logic L = 1'b0;

    typedef struct packed {
        logic        h_n, c_n, a_n, e0_n, e1, e2_n, g_n, b_n;
        logic [3:0]  ln;
        logic [5:0]  ad;
        logic [31:0] di;
        logic        xe;
        logic [31:0] xd;
        int unsigned rq;
    } vec_t;

    localparam vec_t IDLE_V = '{H,H,H,L,H,L,H,H,4'hF,6'd0,32'h0,L,32'h0,0};

    // each row: inputs at one edge, expected bus after that edge
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{H,L,H,L,H,L,L,H,4'hF,6'd4,32'hA0A0A0A0,L,32'h0,4},        // R4 ctl write
        '{H,H,L,L,H,L,L,H,4'hF,6'd0,32'hB1B1B1B1,L,32'h0,8},        // R8 beat 1
        '{H,H,L,L,H,L,L,H,4'hF,6'd0,32'hC2C2C2C2,L,32'h0,8},
        '{H,H,L,L,H,L,L,H,4'hF,6'd0,32'hD3D3D3D3,L,32'h0,8},
        '{H,H,L,L,H,L,H,L,4'b1010,6'd0,32'h11223344,L,32'h0,7},     // R7 wrap, lanes 0,2
        '{H,L,H,L,H,L,H,H,4'hF,6'd4,32'h0,L,32'h0,2},               // R2 read start
        '{H,H,L,L,H,L,H,H,4'hF,6'd0,32'h0,H,32'hA022A044,2},
        '{H,H,H,L,H,L,H,H,4'hF,6'd0,32'h0,H,32'hB1B1B1B1,9},        // R9 suspend
        '{H,L,H,H,H,L,H,H,4'hF,6'd0,32'h0,H,32'hB1B1B1B1,3},        // R3 desel, pending read
        '{H,H,H,L,H,L,H,H,4'hF,6'd0,32'h0,L,32'h0,3},
        '{L,H,H,L,H,L,L,H,4'hF,6'd6,32'hFFFFFFFF,L,32'h0,12},       // R12 host start
        '{H,H,H,L,H,L,H,L,4'b0111,6'd0,32'h99000000,H,32'hC2C2C2C2,5}, // R5 write on 2nd edge
        '{H,L,H,L,L,L,H,H,4'hF,6'd0,32'h0,L,32'h0,1},               // R1 en1 low
        '{H,L,H,L,H,L,H,H,4'hF,6'd6,32'h0,L,32'h0,2},
        '{H,L,H,L,H,H,H,H,4'hF,6'd0,32'h0,H,32'h99C2C2C2,6},        // R6 all-lane write ignored earlier
        '{H,H,H,L,H,L,H,H,4'hF,6'd0,32'h0,L,32'h0,3},
        '{L,H,H,H,H,L,H,H,4'hF,6'd4,32'h0,L,32'h0,1},               // R1 host strobe ignored
        '{H,H,H,L,H,L,H,H,4'hF,6'd0,32'h0,L,32'h0,1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic        mode_il_i = 1'b0;
    logic        en0_n_i, en1_i, en2_n_i;
    logic        strb_host_n_i, strb_ctl_n_i, adv_n_i;
    logic        wr_all_n_i, wr_byte_n_i;
    logic [3:0]  lane_n_i;
    logic        oe_n_i = 1'b0;
    logic [5:0]  addr_i;
    logic [31:0] din_i;
    logic [31:0] dout_o;
    logic        dout_en_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pburst_sram #(.RECOV_CYC(RECOV)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .mode_il_i(mode_il_i),
        .en0_n_i(en0_n_i), .en1_i(en1_i), .en2_n_i(en2_n_i),
        .strb_host_n_i(strb_host_n_i), .strb_ctl_n_i(strb_ctl_n_i), .adv_n_i(adv_n_i),
        .wr_all_n_i(wr_all_n_i), .wr_byte_n_i(wr_byte_n_i), .lane_n_i(lane_n_i),
        .oe_n_i(oe_n_i), .addr_i(addr_i), .din_i(din_i),
        .dout_o(dout_o), .dout_en_o(dout_en_o)
    );

    task automatic put(input vec_t v);
        strb_host_n_i = v.h_n; strb_ctl_n_i = v.c_n; adv_n_i = v.a_n;
        en0_n_i = v.e0_n; en1_i = v.e1; en2_n_i = v.e2_n;
        wr_all_n_i = v.g_n; wr_byte_n_i = v.b_n; lane_n_i = v.ln;
        addr_i = v.ad; din_i = v.di;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input int unsigned rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_bus(input logic xe, input logic [31:0] xd, input int unsigned rq);
        chk(dout_en_o === xe, rq, "drive enable", {31'b0, dout_en_o}, {31'b0, xe});
        if (xe) chk(dout_o === xd, rq, "read data", dout_o, xd);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t v;
        put(IDLE_V);
        step();
        step();
        // R2: nothing driven out of reset
        chk_bus(L, 32'h0, 2);
        rst_n = 1'b1;
        step();

        // vector table, linear order
        foreach (VECS[i]) begin
            put(VECS[i]);
            step();
            chk_bus(VECS[i].xe, VECS[i].xd, VECS[i].rq);
        end

        // R8: interleaved order from odd start address 9 gives 9,8,11,10
        mode_il_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            v = IDLE_V; v.c_n = L; v.g_n = L; v.ad = 6'(8 + i); v.di = {4{8'(8 + i)}};
            put(v);
            step();
        end
        v = IDLE_V; v.c_n = L; v.ad = 6'd9;
        put(v); step();
        v = IDLE_V; v.a_n = L;
        put(v); step(); chk_bus(H, 32'h09090909, 8);
        put(v); step(); chk_bus(H, 32'h08080808, 8);
        put(v); step(); chk_bus(H, 32'h0B0B0B0B, 8);
        v = IDLE_V; v.c_n = L; v.e0_n = H;
        put(v); step(); chk_bus(H, 32'h0A0A0A0A, 8);

        // R10: output enable acts between edges
        oe_n_i = 1'b1; #0.5;
        chk(dout_en_o === L, 10, "oe high drive", {31'b0, dout_en_o}, 32'h0);
        oe_n_i = 1'b0; #0.5;
        chk(dout_en_o === H, 10, "oe low drive", {31'b0, dout_en_o}, 32'h1);
        put(IDLE_V); step();

        // R11: sleep floats the bus, keeps contents, blocks strobes during recovery
        v = IDLE_V; v.c_n = L; v.ad = 6'd8;
        put(v); step();
        v = IDLE_V; v.c_n = L; v.e0_n = H;
        put(v); step();
        chk_bus(H, 32'h08080808, 11);
        sleep_i = 1'b1; #0.5;
        chk(dout_en_o === L, 11, "sleep drive", {31'b0, dout_en_o}, 32'h0);
        put(IDLE_V);
        step(); step();
        sleep_i = 1'b0;
        for (int i = 0; i < RECOV - 1; i++) step();
        v = IDLE_V; v.c_n = L; v.g_n = L; v.ad = 6'd8; v.di = 32'hDEADBEEF;
        put(v); step();   // last edge of the recovery window
        v = IDLE_V; v.c_n = L; v.ad = 6'd8;
        put(v); step();   // first accepted edge
        v = IDLE_V; v.c_n = L; v.e0_n = H;
        put(v); step();
        chk_bus(H, 32'h08080808, 11);
        put(IDLE_V); step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule